// File: doc/BRIEF.md
# Banked Processor Control Register File

This block holds the control state of a small processor core. It has one combinational read port and one synchronous write port, both selected by a 4-bit control index. It stores a status word made of a current byte and a backup byte, a second-level backup status byte, a separate condition flag, two banked stack pointers, two backup program counters and two spare 32-bit registers. It also owns the architectural stack-pointer general register, which is driven on its own output port.

Bit 7 of the current status byte is the stack mode. It decides which of the two banked pointers is live in the stack-pointer register. The other pointer waits in its bank. A status write that flips the mode swaps the live pointer and the banked one in a single clock edge. Reads of the pointer indices are routed to the live register or to the bank, depending on the mode.

Top module: `ctrl_bank_regs`

## Requirements
- R1: After reset, every index reads zero and `sp_live` is zero. The index map is: 0 status, 1 condition, 2 interrupt stack pointer, 3 user stack pointer, 4 and 5 spares, 6 backup PC, 7 second-level backup PC, 8 second-level backup status, 9 to 15 undefined.
- R2: A read of index 0 returns the backup status byte AND 0xC1 in bits 15:8, the current status byte AND 0xC0 in bits 7:0, and the condition flag ORed into bit 0. Bits 31:16 read as zero.
- R3: A write to index 0 loads `wr_data[15:8]` into the backup status byte and `wr_data[7:0]` into the current status byte. It also sets the condition flag from `wr_data[0]`.
- R4: A status write that changes the mode bit from 1 to 0 copies the live pointer into the user bank and loads the live register from the interrupt bank. A change from 0 to 1 copies the live pointer into the interrupt bank and loads the live register from the user bank.
- R5: With mode 0, index 2 reads and writes the live register and index 3 uses the user bank. With mode 1, index 3 uses the live register and index 2 uses the interrupt bank.
- R6: Indices 6 and 7 store all 32 written bits, and reads of them return the value with bit 0 cleared.
- R7: Index 8 stores `wr_data[7:0]` and reads back that byte AND 0xC1, zero-extended.
- R8: Index 1 writes only the condition flag, from `wr_data[0]`, and reads it back in bit 0 with all other bits zero.
- R9: Indices 4 and 5 are plain 32-bit storage.
- R10: Writes to indices 9 to 15 change no state, and reads of those indices return zero.
- R11: A read and a write to the same index in the same cycle return the value held before the write.
- R12: `sp_live` always shows the live stack-pointer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write value |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read value, combinational |
| sp_live | output | 32 | Live stack-pointer general register |

## Verification
The bench writes to every index with patterns whose mode bit and bit 0 vary. After each write it reads back all sixteen indices and the live-pointer port, so swaps in both directions and mode-dependent pointer routing are exercised many times. A design that swaps in the wrong direction, or that routes index 2 or 3 with the mode sense inverted, would return a banked pointer where the live one belongs. A design that skips the read masks would leak status bits 5:1, or bit 0 of a backup PC, into the read data. A design that writes through on a same-index read would return the new value a cycle early. A design that decodes the undefined indices would corrupt a neighbouring register, and the full read sweep after each such write would show it.

// File: rtl/ctrl_bank_regs.sv
module ctrl_bank_regs #(
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    sp_live
);
  localparam logic [IDX_W-1:0] I_STAT = 0, I_COND = 1, I_SPI = 2, I_SPU = 3,
                               I_SPA  = 4, I_SPB  = 5, I_BPC = 6, I_BBPC = 7,
                               I_BBST = 8;
  localparam logic [7:0] KEEP_HI = 8'hC1, KEEP_LO = 8'hC0;

  logic [7:0]    stat_cur, stat_bak, stat_bb;
  logic          cond;
  logic [DW-1:0] sp_int, sp_usr, bpc, bbpc, spare_a, spare_b;
  logic          mode;

  assign mode = stat_cur[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_cur <= '0;
      stat_bak <= '0;
      stat_bb  <= '0;
      cond     <= 1'b0;
      sp_live  <= '0;
      sp_int   <= '0;
      sp_usr   <= '0;
      bpc      <= '0;
      bbpc     <= '0;
      spare_a  <= '0;
      spare_b  <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        I_STAT: begin
          stat_bak <= wr_data[15:8];
          stat_cur <= wr_data[7:0];
          cond     <= wr_data[0];
          if (mode && !wr_data[7]) begin
            sp_usr  <= sp_live;
            sp_live <= sp_int;
          end else if (!mode && wr_data[7]) begin
            sp_int  <= sp_live;
            sp_live <= sp_usr;
          end
        end
        I_COND: cond <= wr_data[0];
        I_SPI:  if (!mode) sp_live <= wr_data; else sp_int <= wr_data;
        I_SPU:  if (mode)  sp_live <= wr_data; else sp_usr <= wr_data;
        I_SPA:  spare_a <= wr_data;
        I_SPB:  spare_b <= wr_data;
        I_BPC:  bpc     <= wr_data;
        I_BBPC: bbpc    <= wr_data;
        I_BBST: stat_bb <= wr_data[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      I_STAT: begin
        rd_data[15:8] = stat_bak & KEEP_HI;
        rd_data[7:0]  = (stat_cur & KEEP_LO) | {7'b0, cond};
      end
      I_COND: rd_data[0] = cond;
      I_SPI:  rd_data = mode ? sp_int : sp_live;
      I_SPU:  rd_data = mode ? sp_live : sp_usr;
      I_SPA:  rd_data = spare_a;
      I_SPB:  rd_data = spare_b;
      I_BPC:  rd_data = {bpc[DW-1:1], 1'b0};
      I_BBPC: rd_data = {bbpc[DW-1:1], 1'b0};
      I_BBST: rd_data[7:0] = stat_bb & KEEP_HI;
      default: rd_data = '0;
    endcase
  end
endmodule

module ctrl_bank_regs_chk #(
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic [IDX_W-1:0] rd_idx,
  input logic [DW-1:0]    rd_data,
  input logic [DW-1:0]    sp_live,
  input logic             mode
);
  assert_spi_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2 && !mode) |=> (sp_live == $past(wr_data)));

  assert_spu_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3 && mode) |=> (sp_live == $past(wr_data)));

  assert_sp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !(wr_idx == 0 || wr_idx == 2 || wr_idx == 3)) |=> $stable(sp_live));

  assert_mode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 0) |=> (mode == $past(wr_data[7])));

  assert_cond_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 1 && rd_idx == 1) |=> (rd_idx != 1 || rd_data == {{(DW-1){1'b0}}, $past(wr_data[0])}));

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > 8) |-> (rd_data == '0));

  assert_bpc_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 6 || rd_idx == 7) |-> !rd_data[0]);
endmodule

bind ctrl_bank_regs ctrl_bank_regs_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .sp_live(sp_live), .mode(mode)
);

// File: tb/test_ctrl_bank_regs.sv
`timescale 1ns/1ps
module test_ctrl_bank_regs;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0, rd_data, sp_live;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0]  m_cur = 0, m_bak = 0, m_bb = 0;
  logic        m_cond = 0;
  logic [31:0] m_live = 0, m_int = 0, m_usr = 0, m_bpc = 0, m_bbpc = 0, m_s4 = 0, m_s5 = 0;

  always #2.5 clk = ~clk;

  ctrl_bank_regs i_ctrl_bank_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .sp_live(sp_live)
  );

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R2/R3";
      1: return "R8";
      2, 3: return "R5";
      4, 5: return "R9";
      6, 7: return "R6";
      8: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int idx);
    case (idx)
      0: return {16'h0, m_bak & 8'hC1, (m_cur & 8'hC0) | {7'b0, m_cond}};
      1: return {31'b0, m_cond};
      2: return m_cur[7] ? m_int : m_live;
      3: return m_cur[7] ? m_live : m_usr;
      4: return m_s4;
      5: return m_s5;
      6: return m_bpc & 32'hFFFF_FFFE;
      7: return m_bbpc & 32'hFFFF_FFFE;
      8: return {24'h0, m_bb & 8'hC1};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(int idx, logic [31:0] v);
    case (idx)
      0: begin
        if (m_cur[7] && !v[7]) begin m_usr = m_live; m_live = m_int; end
        else if (!m_cur[7] && v[7]) begin m_int = m_live; m_live = m_usr; end
        m_bak = v[15:8]; m_cur = v[7:0]; m_cond = v[0];
      end
      1: m_cond = v[0];
      2: if (!m_cur[7]) m_live = v; else m_int = v;
      3: if (m_cur[7]) m_live = v; else m_usr = v;
      4: m_s4 = v;
      5: m_s5 = v;
      6: m_bpc = v;
      7: m_bbpc = v;
      8: m_bb = v[7:0];
      default: ;
    endcase
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(int idx, logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_idx = idx[3:0]; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    model_write(idx, v);
  endtask

  task automatic read_all(string req_all);
    for (int i = 0; i < 16; i++) begin
      rd_idx = i[3:0];
      #0.5;
      check(tag_of(i), $sformatf("%s read idx %0d", req_all, i), rd_data, exp_read(i));
    end
    check("R12/R4", "live pointer port", sp_live, m_live);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_all("R1 reset");

    // R4 directed swap: set pointers in mode 0, enter mode 1, return
    do_write(2, 32'h1111_0000);
    do_write(3, 32'h2222_0000);
    do_write(0, 32'h0000_0080);
    check("R4", "0->1 live from user bank", sp_live, 32'h2222_0000);
    do_write(3, 32'h3333_0000);
    do_write(0, 32'h0000_0000);
    check("R4", "1->0 live from interrupt bank", sp_live, 32'h1111_0000);
    rd_idx = 3; #0.5;
    check("R4", "user bank saved", rd_data, 32'h3333_0000);
    read_all("R4 after swaps");

    // R11 same-cycle read and write
    @(negedge clk);
    wr_en = 1; wr_idx = 4; wr_data = 32'hCAFE_F00D; rd_idx = 4;
    #0.5;
    check("R11", "old value on same-cycle read", rd_data, m_s4);
    @(negedge clk);
    wr_en = 0;
    model_write(4, 32'hCAFE_F00D);
    #0.5;
    check("R11", "new value next cycle", rd_data, 32'hCAFE_F00D);

    // Sweep: every index, varied patterns, full read-back
    for (int p = 0; p < 8; p++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [31:0] v;
        v = 32'h9E37_79B9 * (p * 16 + idx + 1) ^ (32'h0101_0101 << p);
        do_write(idx, v);
        read_all($sformatf("sweep p%0d after write idx %0d", p, idx));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule